// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns a single active-low interrupt pin into a latched interrupt request for a processor core. The pin is first passed through a synchronizer. A high-to-low transition of the synchronized level sets a request latch. An optional level mode keeps the request asserted for as long as the pin stays low. The core clears the request in one of two ways: with the acknowledge strobe it raises during the vector fetch, or by writing a one to the acknowledge bit of a small status/control register.

The status/control register also holds a pending flag, a mask and the mode select. The pending flag shows the request whether or not the mask is set, so software can poll it. The mask only gates the request line sent to the core. While the request is presented, the block drives the address of the high byte of the interrupt vector; the low byte sits at the next address. An enable input turns the whole function on or off. When it is off, no request is captured and the pin-level readback used by branch-on-pin instructions reads as a high pin.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The pin is synchronized through two flops, which reset to 0. A synchronized transition from 1 to 0 sets the request latch when the enable input is high, in either mode.
- R2: With the mode bit (register bit 0) at 0, the request is edge-only. An acknowledge clears the pending flag on the next clock.
- R3: With the mode bit at 1, pending is also true while the synchronized pin is low. It drops only after an acknowledge and the pin returning high have both happened, in either order.
- R4: Writing a 1 to register bit 2 has the same effect as a vector-fetch strobe. Bit 2 always reads 0.
- R5: An acknowledge does not disturb edge detection, so a later falling edge sets the latch again. If an edge and an acknowledge fall in the same cycle, the latch stays set.
- R6: Reset clears the latch, the mask and the mode bit. This removes the request even while the pin is held low.
- R7: The pending flag (register bit 3, read-only) ignores the mask (bit 1). The request output is a registered copy of pending AND NOT mask, one clock later.
- R8: While the request output is high, the vector address output is 0xFFFA; otherwise it is 0.
- R9: With the enable input high, the pin-level output equals the synchronized pin. With it low, that output reads 1, no request is latched, and the level term is suppressed.
- R10: A register write loads the mask from bit 1 and the mode from bit 0. Read data bits 7..4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| func_en | input | 1 | Interrupt function enable |
| vec_fetch | input | 1 | Vector-fetch acknowledge strobe from the core |
| reg_wr | input | 1 | Status/control register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | output | 1 | Masked interrupt request to the core |
| vec_addr | output | 16 | Vector high-byte address while requesting |
| pin_level | output | 1 | Pin level for branch-on-pin instructions |

## Verification
The bench goes after the two orders in which a level-mode request can clear. A design that clears on the acknowledge alone drops pending while the pin is still low. A design that waits for the pin alone never clears after the pin is released first. The bench also lands a falling edge and an acknowledge in the same cycle; a design with the wrong priority loses that interrupt. It holds the pin low through reset, where a synchronizer that resets to 1 would invent an edge, and it sets the mask to show that pending keeps tracking the request while the request line stays low.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_PEND = 3;
  localparam int VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_HI_ADDR = 16'hFFFA;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl_q,
  output logic prev_q
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] chain_q;

  // Chain resets to 0: a pin held low through reset never looks like an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= chain_q[LAST];
    end
  end

  assign lvl_q = chain_q[LAST];
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lvl,
  input  logic prev,
  input  logic ack,
  input  logic level_mode,
  output logic latch_q,
  output logic pending
);
  logic fall;
  assign fall = prev & ~lvl;

  // A new edge wins over an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)       latch_q <= 1'b0;
    else if (!en)  latch_q <= 1'b0;
    else if (fall) latch_q <= 1'b1;
    else if (ack)  latch_q <= 1'b0;
  end

  assign pending = latch_q | (level_mode & en & ~lvl);

  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (en && prev && !lvl) |=> latch_q);
  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (ack && !(prev && !lvl)) |=> !latch_q);
  assert_disabled_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> !latch_q);
  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> !latch_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             pending,
  output logic             mask_q,
  output logic             mode_q,
  output logic             ack_sw,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr) begin
      mask_q <= wdata[BIT_MASK];
      mode_q <= wdata[BIT_MODE];
    end
  end

  assign ack_sw = wr & wdata[BIT_ACK];

  always_comb begin
    rdata           = '0;
    rdata[BIT_PEND] = pending;
    rdata[BIT_MASK] = mask_q;
    rdata[BIT_MODE] = mode_q;
  end

  assert_reset_mode_R6: assert property (@(posedge clk)
    rst |=> (!mode_q && !mask_q));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pin_n,
  input  logic             func_en,
  input  logic             vec_fetch,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] vec_addr,
  output logic             pin_level
);
  logic lvl, prev, latch_q, pending, mask_q, mode_q, ack_sw, ack, req_q;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(irq_pin_n), .lvl_q(lvl), .prev_q(prev));

  assign ack = vec_fetch | ack_sw;

  irq_latch u_latch (
    .clk(clk), .rst(rst), .en(func_en), .lvl(lvl), .prev(prev), .ack(ack),
    .level_mode(mode_q), .latch_q(latch_q), .pending(pending));

  irq_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .pending(pending),
    .mask_q(mask_q), .mode_q(mode_q), .ack_sw(ack_sw), .rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= pending & ~mask_q;
  end

  assign irq_req   = req_q;
  assign vec_addr  = req_q ? VEC_HI_ADDR : '0;
  assign pin_level = func_en ? lvl : 1'b1;

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_req);
  assert_req_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (pending && !mask_q) |=> irq_req);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b1, en = 1'b1, vf = 1'b0, wr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic req, pl;
  logic [15:0] va;
  int checks = 0, errors = 0, cyc = 0;
  string tag = "R6";

  always #2.5 clk = ~clk;

  ext_irq_ctrl u0 (.clk(clk), .rst(rst), .irq_pin_n(pin), .func_en(en),
    .vec_fetch(vf), .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rd),
    .irq_req(req), .vec_addr(va), .pin_level(pl));

  // Behavioural reference model
  int s1 = 0, s2 = 0, s3 = 0, m_lat = 0, m_mask = 0, m_mode = 0, m_req = 0;
  function automatic int m_pend();
    return (m_lat != 0 || (m_mode != 0 && en && s2 == 0)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      s1 = 0; s2 = 0; s3 = 0; m_lat = 0; m_mask = 0; m_mode = 0; m_req = 0;
    end else begin
      bit fall, ack;
      fall  = (s3 == 1 && s2 == 0);
      ack   = vf || (wr && wd[2]);
      m_req = (m_pend() != 0 && m_mask == 0) ? 1 : 0;
      if (!en) m_lat = 0;
      else if (fall) m_lat = 1;
      else if (ack) m_lat = 0;
      if (wr) begin m_mask = wd[1]; m_mode = wd[0]; end
      s3 = s2; s2 = s1; s1 = pin;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd;
    cyc++;
    exp_rd = (m_pend() << 3) | (m_mask << 1) | m_mode;
    chk("rdata", rd, exp_rd);
    chk("irq_req", req, m_req);
    chk("vec_addr", va, m_req ? 16'hFFFA : 0);
    chk("pin_level", pl, en ? s2 : 1);
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      finish_run();
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(logic [7:0] v);
    wd = v; wr = 1'b1; step(1); wr = 1'b0; wd = '0;
  endtask
  task automatic fetch();
    vf = 1'b1; step(1); vf = 1'b0;
  endtask

  initial begin
    step(3);
    tag = "R6"; chk("reset rdata", rd, 0); chk("reset req", req, 0);
    rst = 1'b0; step(4);
    // R1/R2 edge mode, vector fetch clears
    tag = "R1"; pin = 1'b0; step(4); chk("flag set", rd[3], 1);
    tag = "R8"; chk("vector", va, 16'hFFFA);
    tag = "R2"; fetch(); chk("flag cleared", rd[3], 0); pin = 1'b1; step(4);
    // R4 software ack
    tag = "R4"; pin = 1'b0; step(4); wreg(8'h04); chk("sw ack clears", rd[3], 0);
    chk("ack bit reads 0", rd[2], 0); pin = 1'b1; step(4);
    // R3 level mode: ack first, then release
    tag = "R10"; wreg(8'h01); chk("mode readback", rd[1:0], 1);
    tag = "R3"; pin = 1'b0; step(4); fetch(); step(2); chk("held while low", rd[3], 1);
    pin = 1'b1; step(4); chk("cleared after release", rd[3], 0);
    // R3 release first, then ack
    pin = 1'b0; step(4); pin = 1'b1; step(4); chk("latched after release", rd[3], 1);
    wreg(8'h05); chk("cleared after ack", rd[3], 0);
    // R5 re-arm after ack, then edge+ack in same cycle
    tag = "R5"; wreg(8'h00); pin = 1'b0; step(4); fetch(); pin = 1'b1; step(4);
    pin = 1'b0; step(4); chk("new edge re-latches", rd[3], 1); fetch(); pin = 1'b1; step(4);
    pin = 1'b0; step(2); vf = 1'b1; step(1); vf = 1'b0; chk("edge wins", rd[3], 1);
    fetch(); pin = 1'b1; step(4);
    // R7 mask
    tag = "R7"; wreg(8'h02); pin = 1'b0; step(4); chk("flag ignores mask", rd[3], 1);
    chk("req masked", req, 0); wreg(8'h00); step(1); chk("req after unmask", req, 1);
    fetch(); pin = 1'b1; step(4);
    // R6 reset with pin low in level mode
    tag = "R6"; wreg(8'h01); pin = 1'b0; step(4); rst = 1'b1; step(2); rst = 1'b0; step(5);
    chk("cleared through reset", rd, 0); pin = 1'b1; step(4);
    // R9 disabled
    tag = "R9"; en = 1'b0; pin = 1'b0; step(5); chk("no latch", rd[3], 0);
    chk("level reads high", pl, 1); en = 1'b1; step(1); chk("real level", pl, 0);
    pin = 1'b1; step(5);
    finish_run();
  end
endmodule